// File: doc/BRIEF.md
# Event Bitstream Recorder

This block turns an asynchronous event line into an unbroken stream of samples, one bit for each clock. A sample is 1 when the event is asserted and 0 when it is not. The samples are packed into 32-bit words. The stream is cut into fixed-size blocks, and each block is introduced by a two-word header. The header holds a marker, the slot mode, a loss flag and the value of a free-running clock counter taken at the block's first sample. A host reading the words can place every event in time from the block stamp plus the bit's offset within the block.

A second mode shares the slots between the event line and a one-pulse-per-second reference. Odd slots carry the reference and even slots carry the event, so that events can be aligned to the reference afterwards. The event rate is halved in this mode. Words leave the block through a valid/ready port that is fed from a small internal FIFO.

Top module: `evt_stream_capture`

## Requirements
- R1: Every clock after reset yields exactly one sample. The sample taken at clock edge e equals the level of `evt_in` that was present at edge e-2, because the input passes through a two-flop synchronizer.
- R2: Samples are packed MSB-first into 32-bit words. The first sample of a block is bit 31 of that block's first data word. A block has `BLK_WORDS` data words.
- R3: Each block is preceded by two header words. The first is `{16'hE5B1, 14'b0, mode, lost}`, with mode in bit 1 and lost in bit 0. The second is the 32-bit clock counter value at the edge where the block's first sample is taken. The counter is 0 at the first edge after reset and increases by one on every edge.
- R4: No sample is dropped or repeated between blocks. The stamps of consecutive blocks differ by exactly `BLK_WORDS*32`.
- R5: With mode 1, slot k of a block (k counted from 0 at the block's first sample) carries the synchronized `pps_in` when k is odd and the synchronized `evt_in` when k is even. Slot parity restarts at even on every block.
- R6: `ilv_mode` is sampled only at the edge where a block's first sample is taken. That value governs the whole block and is reported in the block's header.
- R7: Once `out_valid` is high, it and `out_data` hold steady until `out_ready` accepts the word. Words come out in the order they were produced.
- R8: A word produced while the FIFO is full is discarded and a sticky loss flag is set. The next first header word that is successfully queued carries lost = 1, and queuing that word clears the flag.
- R9: During and right after reset `out_valid` is low. The first block's stamp is 0 and its lost bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Asynchronous event level |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| ilv_mode | input | 1 | 1 selects reference/event slot sharing, taken at block start |
| out_data | output | 32 | Header or data word |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Consumer accepts the word this edge |

## Verification
The hardest state to reach is a loss. The consumer must stall long enough for the FIFO to fill and for whole words to be discarded. The bench then has to recognise the first block whose header reports the loss, even though the stream before it has gaps. The stimulus holds `out_ready` low for several hundred cycles with the slot sharing off, then releases it. The checker skips words until it finds a marker word with the loss bit set, followed by a stamp on a block boundary, and strict checking resumes from that block. Mode changes are also placed exactly on block-boundary edges and in mid-block, to show which value each block takes.

// File: rtl/evt_stream_capture.sv
module evt_stream_capture #(
  parameter int BLK_WORDS  = 1024,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_in,
  input  logic        pps_in,
  input  logic        ilv_mode,
  output logic [31:0] out_data,
  output logic        out_valid,
  input  logic        out_ready
);
  localparam int W     = 32;
  localparam int BIT_W = $clog2(W);
  localparam int WRD_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [15:0] HDR_MARK = 16'hE5B1;

  logic [1:0]       evt_sync, pps_sync;
  logic [31:0]      tick, stamp_q;
  logic [BIT_W-1:0] bit_idx;
  logic [WRD_W-1:0] word_idx;
  logic [W-2:0]     shreg;
  logic             mode_q, lost_q, hdr2_pend;

  logic [W-1:0]     mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  wire blk_start = (bit_idx == '0) && (word_idx == '0);
  wire word_done = (bit_idx == BIT_W'(W - 1));
  wire cur_mode  = blk_start ? ilv_mode : mode_q;
  wire smp       = (cur_mode && bit_idx[0]) ? pps_sync[1] : evt_sync[1];
  wire full      = (count == CNT_W'(FIFO_DEPTH));
  wire wr_en     = blk_start | hdr2_pend | word_done;
  wire push      = wr_en && !full;
  wire pop       = out_valid && out_ready;

  logic [W-1:0] wr_data;
  always_comb begin
    if (blk_start)      wr_data = {HDR_MARK, 14'b0, ilv_mode, lost_q};
    else if (hdr2_pend) wr_data = stamp_q;
    else                wr_data = {shreg, smp};
  end

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_sync  <= '0;
      pps_sync  <= '0;
      tick      <= '0;
      stamp_q   <= '0;
      bit_idx   <= '0;
      word_idx  <= '0;
      shreg     <= '0;
      mode_q    <= 1'b0;
      lost_q    <= 1'b0;
      hdr2_pend <= 1'b0;
    end else begin
      evt_sync  <= {evt_sync[0], evt_in};
      pps_sync  <= {pps_sync[0], pps_in};
      tick      <= tick + 32'd1;
      bit_idx   <= bit_idx + 1'b1;
      shreg     <= {shreg[W-3:0], smp};
      hdr2_pend <= blk_start;
      if (blk_start) begin
        stamp_q <= tick;
        mode_q  <= ilv_mode;
      end
      if (word_done)
        word_idx <= (word_idx == WRD_W'(BLK_WORDS - 1)) ? '0 : word_idx + 1'b1;
      if (wr_en && full) lost_q <= 1'b1;
      else if (blk_start) lost_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= wr_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/evt_stream_capture_chk.sv
module evt_stream_capture_chk #(
  parameter int CNT_W = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        full,
  input logic        lost_q,
  input logic        blk_start,
  input logic        hdr2_pend,
  input logic        word_done,
  input logic        mode_q,
  input logic [CNT_W-1:0] count
);
  p_reset_idle_r9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_loss_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(full));

  p_full_no_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !out_ready |=> full);

  p_mode_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(mode_q));

  p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !blk_start && !hdr2_pend);
endmodule

bind evt_stream_capture evt_stream_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .full(full), .lost_q(lost_q), .blk_start(blk_start),
  .hdr2_pend(hdr2_pend), .word_done(word_done), .mode_q(mode_q), .count(count)
);

// File: tb/test_evt_stream_capture.sv
`timescale 1ns/1ps
module test_evt_stream_capture;
  localparam int BW    = 4;
  localparam int BBITS = BW * 32;
  localparam int NCYC  = 9000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_in = 1'b0, pps_in = 1'b0, ilv_mode = 1'b0, out_ready = 1'b0;
  logic [31:0] out_data;
  logic out_valid;

  always #5 clk = ~clk;

  evt_stream_capture #(.BLK_WORDS(BW), .FIFO_DEPTH(16)) i_evt_stream_capture (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .pps_in(pps_in),
    .ilv_mode(ilv_mode), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready));

  bit evt_drv [NCYC+4];
  bit pps_drv [NCYC+4];
  bit mode_drv[NCYC+4];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int  ph = 0, widx = 0, hdr_cnt = 0;
  longint last_t = -BBITS, cur_t = 0;
  bit  cur_mode = 0, hdr_lost = 0, resync = 0, lost_seen = 0;

  function automatic bit exp_bit(longint t, bit m, int s);
    longint e = t + s;
    if (e < 2) return 1'b0;
    return (m && s[0]) ? pps_drv[e-2] : evt_drv[e-2];
  endfunction

  function automatic logic [31:0] exp_word(longint t, bit m, int j);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = exp_bit(t, m, j*32 + i);
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic take_word(logic [31:0] w);
    if (resync) begin
      if (ph == 0) begin
        if (w[31:16] == 16'hE5B1 && w[0]) begin cur_mode = w[1]; ph = 1; end
      end else if (w % BBITS == 0) begin
        resync = 0; lost_seen = 1;
        check("R6 mode after loss", {31'b0, cur_mode}, {31'b0, mode_drv[w]});
        cur_t = w; last_t = w; ph = 2; widx = 0;
      end else ph = 0;
      return;
    end
    case (ph)
      0: begin
        check("R3 header marker", {16'b0, w[31:16]}, 32'h0000E5B1);
        check("R8 lost bit", {31'b0, w[0]}, 32'd0);
        cur_mode = w[1]; ph = 1;
      end
      1: begin
        if (hdr_cnt == 0) check("R9 first stamp", w, 32'd0);
        else check("R4 stamp step", w, 32'(last_t + BBITS));
        check("R6 header mode", {31'b0, cur_mode}, {31'b0, mode_drv[w]});
        hdr_cnt++; cur_t = w; last_t = w; ph = 2; widx = 0;
      end
      default: begin
        check(cur_mode ? "R5 interleaved data" : "R1 R2 event data",
              w, exp_word(cur_t, cur_mode, widx));
        widx++;
        if (widx == BW) ph = 0;
      end
    endcase
  endtask

  initial begin
    #1900000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int evt_left, gap_left, pps_cnt, mode_next;
    void'($urandom(32'd7319));
    repeat (4) @(negedge clk);
    check("R9 valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    evt_left = 0; gap_left = 5; pps_cnt = 0; mode_next = 0;
    for (int e = 0; e < NCYC; e++) begin
      if (evt_left > 0) begin evt_in = 1; evt_left--; if (evt_left == 0) gap_left = $urandom_range(2, 40); end
      else if (gap_left > 0) begin evt_in = 0; gap_left--; end
      else begin evt_in = 1; evt_left = $urandom_range(1, 13); end
      pps_cnt = (pps_cnt == 149) ? 0 : pps_cnt + 1;
      pps_in = (pps_cnt < 23);
      if (e >= 2500 && e < 5800) begin
        if (e % BBITS == 0 && $urandom_range(0, 1)) mode_next = !mode_next;
        else if (e % BBITS == 64 && $urandom_range(0, 2) == 0) mode_next = !mode_next;
        else if (e % BBITS == 127 && $urandom_range(0, 3) == 0) mode_next = !mode_next;
      end else mode_next = 0;
      ilv_mode = mode_next[0];
      if (e < 2500)       out_ready = ($urandom_range(0, 3) != 0);
      else if (e < 6000)  out_ready = $urandom_range(0, 1);
      else if (e < 6700)  out_ready = 0;
      else                out_ready = ($urandom_range(0, 4) != 0);
      if (e == 6000) begin resync = 1; ph = 0; end
      evt_drv[e] = evt_in; pps_drv[e] = pps_in; mode_drv[e] = ilv_mode;
      if (e == 0) check("R9 valid after reset", {31'b0, out_valid}, 32'd0);
      if (out_valid && out_ready) take_word(out_data);
      @(negedge clk);
    end
    check("R8 loss reported", {31'b0, lost_seen}, 32'd1);
    check("R4 blocks seen", {31'b0, hdr_cnt > 40}, 32'd1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule